// File: doc/BRIEF.md
# Widening Lane Multiplier

This block multiplies two 64-bit packed source vectors lane by lane and returns a 128-bit vector in which every lane is twice as wide as the source lanes. The element size can be 8, 16 or 32 bits, which gives 8, 4 or 2 lanes. An opcode selects one of three operations. The first is a plain widening multiply. The second is a widening multiply-subtract, which takes each product away from the matching lane of a 128-bit accumulator input. The third is a carry-less (polynomial) multiply.

A signedness input chooses whether source lanes are sign- or zero-extended before the multiply. The polynomial operation always treats its operands as unsigned. In by-scalar form, one lane of the second source, picked by an index, is broadcast and used as the second operand of every lane. Each request is accepted with `in_valid`, and its result is registered with `out_valid` one cycle later. An unsupported element size or opcode is flagged and leaves the stored result untouched.

Top module: `wmul_lane_array`

## Requirements
- R1: `elem_size` 0, 1 and 2 select 8-, 16- and 32-bit source lanes, giving 8, 4 and 2 lanes. Source lane k sits at bits [k*W +: W] of each source. Result lane k sits at bits [k*2W +: 2W] and is 2W bits wide.
- R2: `opcode` 0 is the widening multiply. Both lanes are sign-extended when `is_signed`=1 and zero-extended when it is 0. The product is kept modulo 2^(2W). For W=32 the operands are widened to 64 bits before the multiply.
- R3: `opcode` 1 is multiply-subtract. Each result lane equals the accumulator lane `acc_in`[k*2W +: 2W] minus the widened product, wrapping modulo 2^(2W).
- R4: `opcode` 2 is the carry-less multiply. The result is the XOR, over every set bit i of the first lane, of the second lane shifted left by i. It ignores `is_signed` and treats both operands as unsigned.
- R5: When `by_scalar`=1, the lane of `src_b` numbered by the low log2(lanes) bits of `scal_idx` replaces the second operand of every lane.
- R6: `out_valid` is 1 in the cycle after a cycle with `in_valid`=1, and 0 after a cycle with `in_valid`=0. A legal request updates `result` on that same edge.
- R7: `elem_size`=3 or `opcode`=3 is illegal. The request still raises `out_valid`, together with `out_illegal`=1, and `result` keeps its previous value. A legal request clears `out_illegal`.
- R8: While `in_valid`=0, `result` does not change.
- R9: During reset (`rst_n`=0 at a clock edge), `out_valid`, `out_illegal` and `result` are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 2 | 0 multiply, 1 multiply-subtract, 2 carry-less, 3 illegal |
| elem_size | input | 2 | 0 8-bit, 1 16-bit, 2 32-bit, 3 illegal |
| is_signed | input | 1 | Sign-extend operands (ignored for carry-less) |
| by_scalar | input | 1 | Broadcast one lane of src_b |
| scal_idx | input | 3 | Broadcast lane number |
| src_a | input | 64 | First source vector |
| src_b | input | 64 | Second source vector |
| acc_in | input | 128 | Wide accumulator vector |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Last request was illegal |
| result | output | 128 | Widened result vector |

## Verification
Every result, legal or illegal, is due exactly one rising edge after the cycle in which its request is presented. The bench drives each request on a falling edge and compares all three outputs on the next falling edge. By then the single register stage has loaded and no further edge has passed. Between those two falling edges, the bench's behavioural model advances its own one-deep state to what the design must hold, so idle cycles and illegal requests are checked for an unchanged `result` in exactly the cycle in which a wrong update would show.

// File: rtl/wmul_pkg.sv
// Shared definitions for the widening lane multiplier.
// Assumes a fixed 64-bit source vector, with the result twice as wide.
package wmul_pkg;
    localparam int SRC_W = 64;
    localparam int RES_W = 2 * SRC_W;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_MSUB = 2'd1,
        OP_POLY = 2'd2,
        OP_BAD  = 2'd3
    } wmul_op_e;
endpackage

// File: rtl/wmul_lane.sv
// One lane: widens two EW-bit operands and forms a product, a subtract from
// the accumulator lane, or a carry-less product, all modulo 2^(2*EW).
// Assumes the mode has already been checked to be legal.
module wmul_lane #(
    parameter int EW = 8
) (
    input  logic [1:0]      mode,
    input  logic            is_signed,
    input  logic [EW-1:0]   opa,
    input  logic [EW-1:0]   opb,
    input  logic [2*EW-1:0] acc,
    output logic [2*EW-1:0] res
);
    import wmul_pkg::*;
    localparam int OW = 2 * EW;

    logic          sx;
    logic [OW-1:0] ax, bx, prod, clmul;

    // Extend both operands; the carry-less mode never sign-extends.
    always_comb begin
        sx = is_signed && (mode != OP_POLY);
        ax = sx ? {{EW{opa[EW-1]}}, opa} : {{EW{1'b0}}, opa};
        bx = sx ? {{EW{opb[EW-1]}}, opb} : {{EW{1'b0}}, opb};
        prod = ax * bx;
    end

    // Carry-less product: XOR of shifted copies of opb, one per set bit of opa.
    always_comb begin
        clmul = '0;
        for (int i = 0; i < EW; i++) begin
            if (opa[i]) clmul = clmul ^ ({{EW{1'b0}}, opb} << i);
        end
    end

    // Choose the lane result by mode.
    always_comb begin
        case (mode)
            OP_MSUB: res = acc - prod;
            OP_POLY: res = clmul;
            default: res = prod;
        endcase
    end
endmodule

// File: rtl/wmul_size_group.sv
// All lanes for one element width EW, with an optional broadcast of one
// src_b lane. Assumes SRC_W is a multiple of EW.
module wmul_size_group #(
    parameter int SRC_W = 64,
    parameter int EW    = 8,
    parameter int IW    = 3
) (
    input  logic [1:0]         mode,
    input  logic               is_signed,
    input  logic               by_scalar,
    input  logic [IW-1:0]      idx,
    input  logic [SRC_W-1:0]   src_a,
    input  logic [SRC_W-1:0]   src_b,
    input  logic [2*SRC_W-1:0] acc,
    output logic [2*SRC_W-1:0] res
);
    localparam int NL = SRC_W / EW;
    localparam int OW = 2 * EW;

    logic [EW-1:0] bcast;

    // Pick the broadcast lane of src_b.
    always_comb bcast = src_b[idx*EW +: EW];

    for (genvar k = 0; k < NL; k++) begin : g_lane
        logic [EW-1:0] b_k;
        // Per-lane second operand: own lane or the broadcast one.
        always_comb b_k = by_scalar ? bcast : src_b[k*EW +: EW];

        wmul_lane #(.EW(EW)) u_lane (
            .mode      (mode),
            .is_signed (is_signed),
            .opa       (src_a[k*EW +: EW]),
            .opb       (b_k),
            .acc       (acc[k*OW +: OW]),
            .res       (res[k*OW +: OW])
        );
    end
endmodule

// File: rtl/wmul_lane_array.sv
// Top: widening SIMD multiply over 8/16/32-bit lanes with a one-cycle
// registered result. Every size group computes in parallel and the element
// size picks one. An illegal size or opcode is flagged and keeps the result.
module wmul_lane_array (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   opcode,
    input  logic [1:0]   elem_size,
    input  logic         is_signed,
    input  logic         by_scalar,
    input  logic [2:0]   scal_idx,
    input  logic [63:0]  src_a,
    input  logic [63:0]  src_b,
    input  logic [127:0] acc_in,
    output logic         out_valid,
    output logic         out_illegal,
    output logic [127:0] result
);
    import wmul_pkg::*;

    logic [RES_W-1:0] grp_res [NUM_SIZES];
    logic [RES_W-1:0] next_res;
    logic             bad_req;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int EW = 8 << s;
        localparam int IW = $clog2(SRC_W / EW);
        wmul_size_group #(.SRC_W(SRC_W), .EW(EW), .IW(IW)) u_grp (
            .mode      (opcode),
            .is_signed (is_signed),
            .by_scalar (by_scalar),
            .idx       (scal_idx[IW-1:0]),
            .src_a     (src_a),
            .src_b     (src_b),
            .acc       (acc_in),
            .res       (grp_res[s])
        );
    end

    // Legality check and size selection.
    always_comb begin
        bad_req  = (elem_size == 2'd3) || (opcode == OP_BAD);
        next_res = '0;
        for (int s = 0; s < NUM_SIZES; s++) begin
            if (elem_size == 2'(s)) next_res = grp_res[s];
        end
    end

    // Output register: valid follows the request, result loads only when legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            result      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal <= bad_req;
                if (!bad_req) result <= next_res;
            end
        end
    end
endmodule

// File: rtl/wmul_checker.sv
// Protocol checks for wmul_lane_array, bound onto every instance.
module wmul_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   opcode,
    input logic [1:0]   elem_size,
    input logic         out_valid,
    input logic         out_illegal,
    input logic [127:0] result
);
    logic req_bad;
    always_comb req_bad = (elem_size == 2'd3) || (opcode == 2'd3);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6
    AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_bad) |=> (out_illegal && $stable(result))); // R7
    AST_LEGAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !req_bad) |=> !out_illegal); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R8
endmodule

bind wmul_lane_array wmul_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .opcode      (opcode),
    .elem_size   (elem_size),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .result      (result)
);

// File: tb/tb_wmul_lane_array.sv
module tb_wmul_lane_array;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   opcode = '0;
    logic [1:0]   elem_size = '0;
    logic         is_signed = 1'b0;
    logic         by_scalar = 1'b0;
    logic [2:0]   scal_idx = '0;
    logic [63:0]  src_a = '0;
    logic [63:0]  src_b = '0;
    logic [127:0] acc_in = '0;
    logic         out_valid, out_illegal;
    logic [127:0] result;

    int n_vec = 0;
    int n_bad = 0;
    logic         m_valid = 1'b0, m_ill = 1'b0;
    logic [127:0] m_res = '0;
    string        m_tag = "R9";

    always #2 clk = ~clk;

    wmul_lane_array dut (.*);

    // Behavioural reference for one request (R1..R5).
    function automatic logic [127:0] ref_calc(input logic [1:0] op, input logic [1:0] sz,
            input logic sg, input logic bs, input logic [2:0] idx,
            input logic [63:0] a, input logic [63:0] b, input logic [127:0] acc);
        int ew = 8 << sz;
        int nl = 64 / ew;
        logic [63:0] m1 = (64'd1 << ew) - 1;
        logic [63:0] m2 = (ew == 32) ? '1 : ((64'd1 << (2 * ew)) - 1);
        logic [63:0] sel = (b >> ((int'(idx) % nl) * ew)) & m1;
        logic [127:0] r = '0;
        for (int k = 0; k < nl; k++) begin
            logic [63:0] av = (a >> (k * ew)) & m1;
            logic [63:0] bv = bs ? sel : ((b >> (k * ew)) & m1);
            logic [127:0] accs = acc >> (k * 2 * ew);
            logic [63:0] p = '0;
            if (op == 2'd2) begin
                for (int i = 0; i < ew; i++) if (av[i]) p = p ^ (bv << i);
            end else begin
                if (sg && av[ew-1]) av = av | ~m1;
                if (sg && bv[ew-1]) bv = bv | ~m1;
                p = av * bv;
                if (op == 2'd1) p = accs[63:0] - p;
            end
            p = p & m2;
            r = r | ({64'b0, p} << (k * 2 * ew));
        end
        return r;
    endfunction

    // Compare the outputs with the model state.
    task automatic check_now();
        n_vec++;
        if (out_valid !== m_valid || out_illegal !== m_ill || result !== m_res) begin
            n_bad++;
            $display("FAIL %s: got v=%0b ill=%0b res=%h, expected v=%0b ill=%0b res=%h",
                     m_tag, out_valid, out_illegal, result, m_valid, m_ill, m_res);
        end
    endtask

    // Check the previous request, then present one request and advance the model.
    task automatic step(input logic v, input logic [1:0] op, input logic [1:0] sz,
            input logic sg, input logic bs, input logic [2:0] idx,
            input logic [63:0] a, input logic [63:0] b, input logic [127:0] acc);
        @(negedge clk);
        check_now();
        in_valid = v; opcode = op; elem_size = sz; is_signed = sg;
        by_scalar = bs; scal_idx = idx; src_a = a; src_b = b; acc_in = acc;
        m_valid = v;
        if (!v) m_tag = "R8,R6";
        else if (op == 2'd3 || sz == 2'd3) begin
            m_ill = 1'b1; m_tag = "R7,R6";
        end else begin
            m_ill = 1'b0;
            m_res = ref_calc(op, sz, sg, bs, idx, a, b, acc);
            m_tag = (op == 2'd1) ? "R3,R1" : (op == 2'd2) ? "R4,R1" :
                    bs ? "R5,R2,R1" : "R2,R1,R6";
            if (bs && op != 2'd0) m_tag = {m_tag, ",R5"};
        end
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now(); // R9 reset state
        rst_n = 1'b1;
        // R2 signed 8-bit: -1 * -1 = 1 and -128 * -128 = 0x4000 per lane
        step(1, 0, 0, 1, 0, 0, 64'hFFFF_FFFF_FFFF_8080, 64'hFFFF_FFFF_FFFF_80FF, '0);
        // R2 unsigned 8-bit, same pattern
        step(1, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_8080, 64'hFFFF_FFFF_FFFF_80FF, '0);
        // R2 32-bit signed extremes widened to 64
        step(1, 0, 2, 1, 0, 0, 64'h8000_0000_7FFF_FFFF, 64'h8000_0000_8000_0000, '0);
        step(1, 0, 2, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0002, '0);
        // R3 multiply-subtract with wrap below zero
        step(1, 1, 1, 1, 0, 0, 64'h0003_FFFF_7FFF_0002, 64'h0005_FFFF_7FFF_0003, '0);
        step(1, 1, 2, 0, 0, 0, 64'h0000_0010_0000_0003, 64'h0000_0010_0000_0004,
             128'h0000_0000_0000_0100_0000_0000_0000_000C);
        // R4 carry-less, is_signed set must not matter
        step(1, 2, 0, 1, 0, 0, 64'hFF80_0303_FF80_0303, 64'hFFFF_0303_FFFF_0303, '0);
        step(1, 2, 2, 1, 0, 0, 64'hFFFF_FFFF_8000_0001, 64'hFFFF_FFFF_8000_0001, '0);
        // R5 broadcast highest lane for each size
        step(1, 0, 0, 1, 1, 7, 64'h0102_0304_0506_0708, 64'h8100_0000_0000_0000, '0);
        step(1, 1, 1, 0, 1, 3, 64'h1111_2222_3333_4444, 64'h0002_0000_0000_0000, {8{16'h1234}});
        step(1, 2, 2, 0, 1, 5, 64'h1234_5678_9ABC_DEF0, 64'h0000_0003_0000_0000, '0);
        // R7 illegal size and illegal opcode; R8 idle hold
        step(1, 0, 3, 0, 0, 0, '1, '1, '1);
        step(1, 3, 1, 0, 0, 0, '1, '1, '1);
        step(0, 0, 0, 0, 0, 0, '1, '1, '1);
        step(0, 2, 2, 0, 0, 0, 64'h5, 64'h7, '0);
        // Random mix over all modes and sizes
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] op = 2'($urandom_range(0, 9) == 0 ? 3 : $urandom_range(0, 2));
            logic [1:0] sz = 2'($urandom_range(0, 9) == 0 ? 3 : $urandom_range(0, 2));
            step(1'($urandom_range(0, 5) != 0), op, sz, 1'($urandom), 1'($urandom),
                 3'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom});
        end
        @(negedge clk);
        check_now();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule